// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with Keyed Write Protection

This peripheral watches for software that has stopped running. Once enabled, it counts ticks of a selected clock. When a programmable first interval runs out, it raises an interrupt so that software can recover. If software then fails to restart the count within a programmable second interval, the block raises a reset request. That request is meant for the system reset controller.

The block sits on a simple word-addressed register bus with four registers: a key register, a control register, a restart register and a status register. The control register and the restart register are protected. A write to either takes effect only when the bus write just before it placed the unlock key in the key register. A restart also needs its own key value in the data.

The counter can follow one of two clocks. One is the peripheral clock. The other is a slow external clock of about 32 kHz, which arrives here already synchronised as a level signal. On the slow clock, each rising edge counts as one tick.

Top module: `twostage_wdt`

## Requirements
- R1: After system reset, `irq_o` and `rst_req_o` are 0, and both the control register and the status register read as 0.
- R2: Register word addresses are: key 0, control 1, restart 2, status 3. A write of 0x5AA5 to address 0 arms an unlock. A write to address 1 or 2 made while no unlock is armed is ignored.
- R3: An armed unlock is used up by the very next bus write to any address, whatever that write is.
- R4: A write of 0xCAFE to address 2 while an unlock is armed sets the counter to zero, so the timeout sequence starts again. A write of any other value, or a write made without an unlock, changes nothing.
- R5: The interrupt stage trips when the count reaches the interrupt limit. Control bits [7:4] hold a 4-bit code, and codes 0 to 15 select 64, 256, 1K, 2K, 4K, 8K, 16K, 32K, 128K, 512K, 2M, 8M, 32M, 128M, 512M and 2G ticks.
- R6: The reset stage trips when the count reaches the interrupt limit plus the reset interval. The reset interval is 128·2^n ticks, where n is the 3-bit code in control bits [10:8].
- R7: Reading address 3 returns the interrupt-stage flag in bit 0 and the reset-stage flag in bit 1. Writing a 1 to either bit clears that flag, and writing a 0 leaves it unchanged.
- R8: While control bit 0 (enable) is 0, the counter stays at zero. The count therefore starts from zero when the block is enabled.
- R9: `irq_o` equals status bit 0 ANDed with control bit 2 (interrupt enable).
- R10: `rst_req_o` goes high when status bit 1 is set and control bit 1 (reset enable) is 1. It then stays high until system reset, even if the flag is cleared or the block is disabled.
- R11: Control bit 3 selects the tick source. When it is 1, the counter advances on every clock cycle. When it is 0, the counter advances once per rising edge of `ext_clk_lvl`, however long the level stays high.
- R12: A restart clears status bit 0 only if status bit 1 is 0. Once the reset stage has been reached, a restart leaves bit 0 set.
- R13: The control register reads back the fields as they were written: enable in bit 0, reset enable in bit 1, interrupt enable in bit 2, clock select in bit 3, and the codes in bits [7:4] and [10:8].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low system reset, released synchronously inside the block |
| ext_clk_lvl | input | 1 | Synchronised level of the slow external clock |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq_o | output | 1 | Interrupt request |
| rst_req_o | output | 1 | Reset request to the system reset controller |

## Verification
The assertions check several properties on every cycle. The control register changes only on a write that follows an unlock, and the unlock falls away after any other write. The counter is zero after any cycle in which the block is disabled. The reset-stage flag never rises without the interrupt-stage flag, and a restart after the reset stage keeps the interrupt flag. The reset request never drops, and a slow-clock level that stays high produces only one tick.

Other behaviour needs the bench's scenarios. These include the exact trip cycles that each interval code gives, and the cases where key mismatches or missing unlocks are ignored. They also include restarting the sequence, counting slow-clock edges, and the reset request clearing on system reset.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam int DATA_W = 32;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_KEY     = 2'd0,
    A_CTRL    = 2'd1,
    A_RESTART = 2'd2,
    A_STATUS  = 2'd3
  } wdt_addr_e;

  // Bit 0 is en. The struct lists fields from the most significant bit down.
  typedef struct packed {
    logic [2:0] rst_code;
    logic [3:0] irq_code;
    logic       clk_sel;
    logic       irq_en;
    logic       rst_en;
    logic       en;
  } wdt_ctrl_t;

  localparam int CTRL_W = $bits(wdt_ctrl_t);

  // The interrupt interval is 2^shift ticks. Exponents per code:
  // 6, 8, then 10 to 15, then odd values 17 to 31.
  function automatic logic [4:0] irq_shift(input logic [3:0] code);
    if (code < 4'd2)      return 5'(32'd6 + 32'(code) * 2);
    else if (code < 4'd8) return 5'(32'd8 + 32'(code));
    else                  return 5'(32'd1 + 32'(code) * 2);
  endfunction

  function automatic logic [4:0] rst_shift(input logic [2:0] code);
    return 5'(32'd7 + 32'(code));
  endfunction

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter logic [DATA_W-1:0] KEY_UNLOCK  = 32'h0000_5AA5,
  parameter logic [DATA_W-1:0] KEY_RESTART = 32'h0000_CAFE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [1:0]        st_q,
  output logic [DATA_W-1:0] bus_rdata,
  output wdt_ctrl_t         ctrl_q,
  output logic              restart_p,
  output logic [1:0]        st_clr
);

  logic      wr;
  logic      unlock_q, unlock_d;
  wdt_ctrl_t ctrl_d;
  logic      ctrl_we;

  assign wr = bus_sel & bus_wr;

  always_comb begin
    unlock_d = unlock_q;
    if (wr) unlock_d = (bus_addr == A_KEY) && (bus_wdata == KEY_UNLOCK);
  end

  assign ctrl_we   = wr && (bus_addr == A_CTRL) && unlock_q;
  assign restart_p = wr && (bus_addr == A_RESTART) && unlock_q &&
                     (bus_wdata == KEY_RESTART);
  assign st_clr    = (wr && (bus_addr == A_STATUS)) ? bus_wdata[1:0] : 2'b00;

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_we) ctrl_d = wdt_ctrl_t'(bus_wdata[CTRL_W-1:0]);
  end

  always_comb begin
    case (bus_addr)
      A_CTRL:   bus_rdata = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
      A_STATUS: bus_rdata = {{(DATA_W-2){1'b0}}, st_q};
      default:  bus_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlock_q <= 1'b0;
      ctrl_q   <= '0;
    end else begin
      unlock_q <= unlock_d;
      ctrl_q   <= ctrl_d;
    end
  end

  // R2: control changes only on a write that follows an unlock
  a_r2_ctrl_locked: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_q) |-> $past(wr && (bus_addr == A_CTRL) && unlock_q));

  // R3: any write other than the key write leaves no unlock armed
  a_r3_unlock_oneshot: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !((bus_addr == A_KEY) && (bus_wdata == KEY_UNLOCK))) |=> !unlock_q);

endmodule

// File: rtl/wdt_tick.sv
module wdt_tick (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_fast,
  input  logic ext_lvl,
  output logic tick
);

  logic prev_q;

  assign tick = sel_fast ? 1'b1 : (ext_lvl & ~prev_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= ext_lvl;
  end

  // R11: a slow-clock level that stays high produces one tick only
  a_r11_single_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_fast && tick && ext_lvl && !$changed(sel_fast)) |=> (sel_fast || !tick));

endmodule

// File: rtl/wdt_core.sv
module wdt_core
  import wdt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       tick,
  input  logic       restart,
  input  logic [3:0] irq_code,
  input  logic [2:0] rst_code,
  input  logic [1:0] st_clr,
  output logic [1:0] st_q
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic [CNT_W-1:0] irq_lim, tot_lim;
  logic             adv, hit_irq, hit_rst;
  logic [1:0]       st_d;

  assign irq_lim = ONE << irq_shift(irq_code);
  assign tot_lim = irq_lim + (ONE << rst_shift(rst_code));

  assign cnt_inc = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + ONE;
  assign adv     = en && tick && !restart;
  assign hit_irq = adv && (cnt_inc >= irq_lim);
  assign hit_rst = adv && (cnt_inc >= tot_lim);

  always_comb begin
    if (restart || !en) cnt_d = '0;
    else if (tick)      cnt_d = cnt_inc;
    else                cnt_d = cnt_q;
  end

  always_comb begin
    st_d[1] = hit_rst | (st_q[1] & ~st_clr[1]);
    st_d[0] = hit_irq | (st_q[0] & ~st_clr[0] & ~(restart & ~st_q[1]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      st_q  <= 2'b00;
    end else begin
      cnt_q <= cnt_d;
      st_q  <= st_d;
    end
  end

  // R8: a disabled cycle leaves the counter at zero
  a_r8_off_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt_q == '0));

  // R6: the reset stage is never reached ahead of the interrupt stage
  a_r6_stage_order: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q[1]) |-> st_q[0]);

  // R12: a restart after the reset stage keeps the interrupt flag
  a_r12_keep_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && st_q[1] && st_q[0]) |=> st_q[0]);

  // R4: a restart brings the counter to zero
  a_r4_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0));

endmodule

// File: rtl/twostage_wdt.sv
module twostage_wdt
  import wdt_pkg::*;
#(
  parameter int                CNT_W       = 32,
  parameter logic [DATA_W-1:0] KEY_UNLOCK  = 32'h0000_5AA5,
  parameter logic [DATA_W-1:0] KEY_RESTART = 32'h0000_CAFE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_clk_lvl,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o,
  output logic              rst_req_o
);

  logic [1:0] rsync_q;
  logic       rst_l;
  wdt_ctrl_t  ctrl;
  logic       restart_p, tick, sticky_q, sticky_d;
  logic [1:0] st_q, st_clr;

  // Reset asserts asynchronously and is released after two clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_l = rsync_q[1];

  wdt_regs #(
    .KEY_UNLOCK (KEY_UNLOCK),
    .KEY_RESTART(KEY_RESTART)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_l),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .st_q     (st_q),
    .bus_rdata(bus_rdata),
    .ctrl_q   (ctrl),
    .restart_p(restart_p),
    .st_clr   (st_clr)
  );

  wdt_tick u_tick (
    .clk     (clk),
    .rst_n   (rst_l),
    .sel_fast(ctrl.clk_sel),
    .ext_lvl (ext_clk_lvl),
    .tick    (tick)
  );

  wdt_core #(.CNT_W(CNT_W)) u_core (
    .clk     (clk),
    .rst_n   (rst_l),
    .en      (ctrl.en),
    .tick    (tick),
    .restart (restart_p),
    .irq_code(ctrl.irq_code),
    .rst_code(ctrl.rst_code),
    .st_clr  (st_clr),
    .st_q    (st_q)
  );

  assign sticky_d  = sticky_q | (st_q[1] & ctrl.rst_en);
  assign rst_req_o = sticky_d;
  assign irq_o     = st_q[0] & ctrl.irq_en;

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) sticky_q <= 1'b0;
    else        sticky_q <= sticky_d;
  end

  // R10: once raised, the reset request holds until system reset
  a_r10_rst_sticky: assert property (@(posedge clk) disable iff (!rst_l)
    rst_req_o |=> rst_req_o);

  // R9: no interrupt without the interrupt-stage flag
  a_r9_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_l)
    irq_o |-> st_q[0]);

endmodule

// File: tb/sim_twostage_wdt.sv
module sim_twostage_wdt;

  localparam int CLK_T = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_clk_lvl = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o, rst_req_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_T/2) clk = ~clk;

  twostage_wdt u0 (
    .clk(clk), .rst_n(rst_n), .ext_clk_lvl(ext_clk_lvl),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .rst_req_o(rst_req_o)
  );

  // Each row: irq code [47:44], reset code [43:40],
  // ticks to interrupt [39:20], ticks to reset [19:0]
  localparam logic [47:0] VEC [4] = '{
    {4'd0, 4'd0, 20'd64,   20'd192},
    {4'd1, 4'd1, 20'd256,  20'd512},
    {4'd2, 4'd0, 20'd1024, 20'd1152},
    {4'd0, 4'd3, 20'd64,   20'd1088}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bwr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic brd(input logic [1:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic unlock();
    bwr(2'd0, 32'h5AA5);
  endtask

  task automatic prot_wr(input logic [1:0] a, input logic [31:0] d);
    unlock();
    bwr(a, d);
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Disable, clear both flags, then enable with the given control value.
  task automatic fresh_start(input logic [31:0] c);
    prot_wr(2'd1, 32'h0);
    bwr(2'd3, 32'h3);
    prot_wr(2'd1, c);
  endtask

  task automatic slow_pulse();
    @(negedge clk); ext_clk_lvl = 1'b1;
    @(negedge clk);
    @(negedge clk); ext_clk_lvl = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(5);

    // R1 reset state
    chk("R1 irq", 32'(irq_o), 0);
    chk("R1 rst", 32'(rst_req_o), 0);
    brd(2'd3, d); chk("R1 status", d, 0);
    brd(2'd1, d); chk("R1 ctrl", d, 0);

    // R2 protected writes
    bwr(2'd1, 32'h20C);
    brd(2'd1, d); chk("R2 ctrl write without key ignored", d, 0);
    bwr(2'd0, 32'h1234); bwr(2'd1, 32'h20C);
    brd(2'd1, d); chk("R2 wrong key ignored", d, 0);
    // R3 one-shot
    unlock(); bwr(2'd3, 32'h0); bwr(2'd1, 32'h20C);
    brd(2'd1, d); chk("R3 unlock consumed by other write", d, 0);
    unlock(); bwr(2'd1, 32'h20C); bwr(2'd1, 32'h000);
    brd(2'd1, d); chk("R3 second write after one unlock ignored", d, 32'h20C);
    // R13 field positions
    prot_wr(2'd1, 32'h75E);
    brd(2'd1, d); chk("R13 ctrl readback", d, 32'h75E);
    prot_wr(2'd1, 32'h0);

    // Table walk: R5, R6, R7, R9
    for (int i = 0; i < 4; i++) begin
      logic [31:0] c;
      int t_irq, t_tot;
      c = {21'd0, VEC[i][42:40], VEC[i][47:44], 4'b1101};
      t_irq = int'(VEC[i][39:20]);
      t_tot = int'(VEC[i][19:0]);
      fresh_start(c);
      wait_cyc(t_irq - 1);
      brd(2'd3, d); chk("R5 before interrupt limit", d, 0);
      wait_cyc(1);
      brd(2'd3, d); chk("R5 interrupt flag at limit", d, 1);
      chk("R9 irq with enable", 32'(irq_o), 1);
      wait_cyc(t_tot - t_irq - 1);
      brd(2'd3, d); chk("R6 before reset stage", d, 1);
      chk("R10 no request with reset disabled", 32'(rst_req_o), 0);
      wait_cyc(1);
      brd(2'd3, d); chk("R6 reset flag at sum", d, 3);
    end
    prot_wr(2'd1, 32'h0);
    bwr(2'd1, 32'h0);
    bwr(2'd3, 32'h1);
    brd(2'd3, d); chk("R7 clear bit0 only", d, 2);
    bwr(2'd3, 32'h2);
    brd(2'd3, d); chk("R7 clear bit1", d, 0);

    // R9 interrupt enable off; R4 restart rules
    fresh_start(32'h009);
    wait_cyc(64);
    brd(2'd3, d); chk("R9 flag set", d, 1);
    chk("R9 irq masked", 32'(irq_o), 0);
    prot_wr(2'd2, 32'hBEEF);
    brd(2'd3, d); chk("R4 wrong restart key ignored", d, 1);
    bwr(2'd2, 32'hCAFE);
    brd(2'd3, d); chk("R4 restart without unlock ignored", d, 1);
    prot_wr(2'd2, 32'hCAFE);
    brd(2'd3, d); chk("R12 restart clears bit0 before reset stage", d, 0);
    wait_cyc(63);
    brd(2'd3, d); chk("R4 count restarted", d, 0);
    wait_cyc(1);
    brd(2'd3, d); chk("R4 interrupt 64 after restart", d, 1);

    // R8 disabled hold
    prot_wr(2'd1, 32'h0);
    bwr(2'd3, 32'h3);
    wait_cyc(300);
    brd(2'd3, d); chk("R8 disabled no flags", d, 0);
    prot_wr(2'd1, 32'h00D);
    wait_cyc(63);
    brd(2'd3, d); chk("R8 count starts at zero", d, 0);
    wait_cyc(1);
    brd(2'd3, d); chk("R8 interrupt at 64", d, 1);
    // R12 restart after reset stage
    wait_cyc(128);
    brd(2'd3, d); chk("R12 reset stage reached", d, 3);
    prot_wr(2'd2, 32'hCAFE);
    brd(2'd3, d); chk("R12 bit0 kept after reset stage", d, 3);

    // R11 slow clock
    fresh_start(32'h005);
    wait_cyc(100);
    brd(2'd3, d); chk("R11 no count without slow edges", d, 0);
    for (int k = 0; k < 63; k++) slow_pulse();
    brd(2'd3, d); chk("R11 63 slow edges", d, 0);
    @(negedge clk); ext_clk_lvl = 1'b1;
    @(negedge clk);
    brd(2'd3, d); chk("R11 64th slow edge trips", d, 1);
    chk("R11 irq", 32'(irq_o), 1);
    ext_clk_lvl = 1'b0;

    // R10 sticky reset request
    fresh_start(32'h00F);
    wait_cyc(191);
    chk("R10 no request yet", 32'(rst_req_o), 0);
    wait_cyc(1);
    chk("R10 request at 192", 32'(rst_req_o), 1);
    prot_wr(2'd1, 32'h0);
    bwr(2'd3, 32'h3);
    brd(2'd3, d); chk("R7 flags cleared", d, 0);
    chk("R10 request held after clear and disable", 32'(rst_req_o), 1);
    @(negedge clk); rst_n = 1'b0;
    #1;
    chk("R1 request cleared by reset", 32'(rst_req_o), 0);
    chk("R1 irq cleared by reset", 32'(irq_o), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule